// File: doc/BRIEF.md
# Receive Queue with Trigger and Timeout Interrupts

This block is the receive-side queue of a 16550-style serial controller. A deserialiser upstream hands it one character at a time, together with that character's parity, framing and break flags. The block stores character and flags as one entry in a 16-deep first-in first-out queue. The host pops entries with a read strobe and sees the oldest entry's byte and flags at the head outputs.

Two interrupt sources come from the queue. The trigger interrupt fires when the occupancy reaches a level chosen through the queue-control write. The timeout interrupt fires when data has sat in the queue for four character times with neither a new arrival nor a host read. A character-time tick from the baud logic paces the timeout.

The queue-control write enables or disables queue mode, flushes the queue and selects the trigger level. With queue mode off, the block behaves as a one-character holding register. A received break loads a single zero character. Loading then stays off until the line has returned to mark and a fresh start bit has been seen.

Top module: `rxq_fifo`

## Requirements
- R1: After reset the queue is empty and queue mode is off: data_ready, trig_irq, to_irq, overrun and fifo_err are all 0.
- R2: Entries leave in arrival order, and head_data shows the oldest stored byte. data_ready is 1 exactly while at least one entry is stored.
- R3: In queue mode, the trigger level comes from fcr_data[7:6] of a control write that has fcr_data[0]=1: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14 entries. trig_irq is 1 while the occupancy is at or above the level, and 0 as soon as it drops below.
- R4: In queue mode, to_irq rises once four char_tick pulses have arrived with the queue non-empty and with no arrival and no host_rd since the last restart. Each accepted arrival and each host_rd restarts the count, so a read clears to_irq.
- R5: A control write with fcr_data[0]=1 and fcr_data[1]=1 empties the queue. The flush acts only on that write: later writes with fcr_data[1]=0 leave stored data in place.
- R6: A control write with fcr_data[0]=0 empties the queue and turns queue mode off.
- R7: An arrival while the queue is full and not being read in the same cycle sets overrun and discards the new character, leaving the stored entries unchanged. overrun stays set until lsr_rd.
- R8: head_perr, head_ferr and head_brk show the flags stored with the head entry only, so an error becomes visible when its character reaches the head.
- R9: fifo_err is 1 while any stored entry carries an error flag. Once an errored entry has been popped, fifo_err stays 1 until the next lsr_rd.
- R10: An arrival with rx_brk=1 stores the byte 0x00 with its break flag set. Later arrivals are ignored until line_mark has been seen and then a start_seen pulse.
- R11: With queue mode off the block holds one character. A second arrival before a read is an overrun, trig_irq follows data_ready, and to_irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received-character strobe |
| rx_byte | input | 8 | Received character |
| rx_perr | input | 1 | Parity error on this character |
| rx_ferr | input | 1 | Framing error on this character |
| rx_brk | input | 1 | Break detected on this character |
| line_mark | input | 1 | Serial line currently at mark level |
| start_seen | input | 1 | Valid start bit detected |
| host_rd | input | 1 | Host pops the head entry |
| lsr_rd | input | 1 | Host reads line status (clears sticky flags) |
| fcr_wr | input | 1 | Queue-control write strobe |
| fcr_data | input | 8 | Queue-control write value |
| char_tick | input | 1 | One pulse per character time |
| head_data | output | 8 | Byte at the head of the queue |
| head_perr | output | 1 | Head entry parity error |
| head_ferr | output | 1 | Head entry framing error |
| head_brk | output | 1 | Head entry break flag |
| data_ready | output | 1 | Queue holds at least one entry |
| overrun | output | 1 | Sticky overrun flag |
| fifo_err | output | 1 | Any error in queue, sticky until lsr_rd |
| trig_irq | output | 1 | Trigger-level interrupt |
| to_irq | output | 1 | Character-timeout interrupt |

## Verification
All outputs come straight from registers, so every result of a stimulus applied in one cycle appears one clock edge later. This covers occupancy, head data, data_ready, trig_irq, overrun and fifo_err after an arrival, pop, status read or control write. to_irq rises in the cycle after the edge that registers the fourth tick, and falls one edge after a read or an arrival. The bench drives each stimulus for exactly one cycle, just after a rising edge, and samples outputs two time units after the following edge. A monitor compares head_data against the scoreboard at the falling edge of each read cycle, before the pop takes effect.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
    logic       brk;
  } rxq_entry_t;

  typedef enum logic [1:0] {
    GATE_OPEN,
    GATE_WAIT_MARK,
    GATE_WAIT_START
  } rxq_gate_e;

  // occupancy threshold selected by the two trigger-code bits
  function automatic logic [7:0] trig_level(input logic [1:0] code);
    case (code)
      2'b00:   trig_level = 8'd1;
      2'b01:   trig_level = 8'd4;
      2'b10:   trig_level = 8'd8;
      default: trig_level = 8'd14;
    endcase
  endfunction

  function automatic logic has_err(input rxq_entry_t e);
    has_err = e.perr | e.ferr | e.brk;
  endfunction

endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic                pop,
  input  logic                flush,
  input  rxq_pkg::rxq_entry_t wdata,
  output rxq_pkg::rxq_entry_t rdata,
  output logic [CW-1:0]       count,
  output logic [CW-1:0]       err_cnt
);
  import rxq_pkg::*;

  rxq_entry_t          mem [DEPTH];
  logic [AW-1:0]       wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CW-1:0]       count_d, err_cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdata = mem[rd_ptr];

  always_comb begin
    wr_ptr_d  = wr_ptr;
    rd_ptr_d  = rd_ptr;
    count_d   = count;
    err_cnt_d = err_cnt;
    if (flush) begin
      wr_ptr_d  = '0;
      rd_ptr_d  = '0;
      count_d   = '0;
      err_cnt_d = '0;
    end else begin
      if (push) wr_ptr_d = bump(wr_ptr);
      if (pop)  rd_ptr_d = bump(rd_ptr);
      case ({push, pop})
        2'b10:   count_d = count + 1'b1;
        2'b01:   count_d = count - 1'b1;
        default: count_d = count;
      endcase
      case ({push && has_err(wdata), pop && has_err(rdata)})
        2'b10:   err_cnt_d = err_cnt + 1'b1;
        2'b01:   err_cnt_d = err_cnt - 1'b1;
        default: err_cnt_d = err_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      wr_ptr  <= wr_ptr_d;
      rd_ptr  <= rd_ptr_d;
      count   <= count_d;
      err_cnt <= err_cnt_d;
    end
  end

  // storage array: write-enabled, no reset
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

endmodule

// File: rtl/rxq_tmo.sv
module rxq_tmo #(
  parameter int TICKS = 4,
  localparam int NW = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic restart,
  input  logic tick,
  output logic fire
);
  logic [NW-1:0] cnt, cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (restart || !armed)
      cnt_d = '0;
    else if (tick && (cnt != NW'(TICKS)))
      cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign fire = armed && (cnt == NW'(TICKS));

endmodule

// File: rtl/rxq_brk_gate.sv
module rxq_brk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_load,
  input  logic line_mark,
  input  logic start_seen,
  output logic open
);
  import rxq_pkg::*;

  rxq_gate_e st, st_d;

  always_comb begin
    st_d = st;
    case (st)
      GATE_OPEN:       if (brk_load)   st_d = GATE_WAIT_MARK;
      GATE_WAIT_MARK:  if (line_mark)  st_d = GATE_WAIT_START;
      GATE_WAIT_START: if (start_seen) st_d = GATE_OPEN;
      default:                         st_d = GATE_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= GATE_OPEN;
    else        st <= st_d;
  end

  assign open = (st == GATE_OPEN);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH    = 16,
  parameter int TO_TICKS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       line_mark,
  input  logic       start_seen,
  input  logic       host_rd,
  input  logic       lsr_rd,
  input  logic       fcr_wr,
  input  logic [7:0] fcr_data,
  input  logic       char_tick,
  output logic [7:0] head_data,
  output logic       head_perr,
  output logic       head_ferr,
  output logic       head_brk,
  output logic       data_ready,
  output logic       overrun,
  output logic       fifo_err,
  output logic       trig_irq,
  output logic       to_irq
);
  import rxq_pkg::*;

  logic          fifo_en_q, fifo_en_d;
  logic [1:0]    trig_q, trig_d;
  logic          ovr_q, ovr_d;
  logic          errseen_q, errseen_d;
  logic [CW-1:0] q_count, err_cnt, depth_lim, lvl;
  logic          nonempty, full, do_pop, do_push, flush, arrive, gate_open;
  rxq_entry_t    wentry, hentry;
  logic [3:0]    fcr_unused;

  assign fcr_unused = fcr_data[5:2];

  // control decode
  assign flush     = fcr_wr && (!fcr_data[0] || fcr_data[1]);
  assign depth_lim = fifo_en_q ? CW'(DEPTH) : CW'(1);
  assign nonempty  = (q_count != '0);
  assign full      = (q_count >= depth_lim);
  assign do_pop    = host_rd && nonempty && !flush;
  assign arrive    = rx_valid && gate_open;
  assign do_push   = arrive && (!full || do_pop) && !flush;
  assign lvl       = CW'(trig_level(trig_q));

  always_comb begin
    wentry.data = rx_brk ? 8'h00 : rx_byte;
    wentry.perr = rx_perr;
    wentry.ferr = rx_ferr;
    wentry.brk  = rx_brk;
  end

  always_comb begin
    fifo_en_d = fcr_wr ? fcr_data[0] : fifo_en_q;
    trig_d    = (fcr_wr && fcr_data[0]) ? fcr_data[7:6] : trig_q;
    ovr_d     = ovr_q;
    if (arrive && full && !do_pop && !flush) ovr_d = 1'b1;
    else if (lsr_rd)                         ovr_d = 1'b0;
    errseen_d = errseen_q;
    if (do_pop && has_err(hentry)) errseen_d = 1'b1;
    else if (lsr_rd)               errseen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      trig_q    <= 2'b00;
      ovr_q     <= 1'b0;
      errseen_q <= 1'b0;
    end else begin
      fifo_en_q <= fifo_en_d;
      trig_q    <= trig_d;
      ovr_q     <= ovr_d;
      errseen_q <= errseen_d;
    end
  end

  rxq_mem #(.DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (do_push),
    .pop     (do_pop),
    .flush   (flush),
    .wdata   (wentry),
    .rdata   (hentry),
    .count   (q_count),
    .err_cnt (err_cnt)
  );

  rxq_tmo #(.TICKS(TO_TICKS)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (nonempty && fifo_en_q),
    .restart (do_push || host_rd || flush),
    .tick    (char_tick),
    .fire    (to_irq)
  );

  rxq_brk_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk_load   (do_push && rx_brk),
    .line_mark  (line_mark),
    .start_seen (start_seen),
    .open       (gate_open)
  );

  assign data_ready = nonempty;
  assign head_data  = nonempty ? hentry.data : 8'h00;
  assign head_perr  = nonempty && hentry.perr;
  assign head_ferr  = nonempty && hentry.ferr;
  assign head_brk   = nonempty && hentry.brk;
  assign overrun    = ovr_q;
  assign fifo_err   = (err_cnt != '0) || errseen_q;
  assign trig_irq   = fifo_en_q ? (q_count >= lvl) : nonempty;

endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          host_rd,
  input logic          fcr_wr,
  input logic [7:0]    fcr_data,
  input logic          data_ready,
  input logic          overrun,
  input logic          trig_irq,
  input logic          to_irq,
  input logic          fifo_en,
  input logic          gate_open,
  input logic [CW-1:0] count
);

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r3_trig_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    trig_irq |-> data_ready);

  a_r4_to_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    to_irq |-> data_ready);

  a_r4_read_clears_to: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> !to_irq);

  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && fcr_data[0] && fcr_data[1]) |=> !data_ready);

  a_r6_disable_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && !fcr_data[0]) |=> !data_ready);

  a_r7_ovr_from_arrival: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_valid));

  a_r10_closed_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && rx_valid && !host_rd && !fcr_wr) |=> $stable(count));

  a_r11_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (count <= CW'(1)));

endmodule

bind rxq_fifo rxq_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .host_rd    (host_rd),
  .fcr_wr     (fcr_wr),
  .fcr_data   (fcr_data),
  .data_ready (data_ready),
  .overrun    (overrun),
  .trig_irq   (trig_irq),
  .to_irq     (to_irq),
  .fifo_en    (fifo_en_q),
  .gate_open  (gate_open),
  .count      (q_count)
);

// File: tb/rxq_fifo_bench.sv
module rxq_fifo_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, rx_valid, rx_perr, rx_ferr, rx_brk, line_mark, start_seen;
  logic host_rd, lsr_rd, fcr_wr, char_tick;
  logic [7:0] rx_byte, fcr_data, head_data;
  logic head_perr, head_ferr, head_brk, data_ready, overrun, fifo_err, trig_irq, to_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_fifo u_rxq_fifo (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .line_mark(line_mark), .start_seen(start_seen), .host_rd(host_rd),
    .lsr_rd(lsr_rd), .fcr_wr(fcr_wr), .fcr_data(fcr_data), .char_tick(char_tick),
    .head_data(head_data), .head_perr(head_perr), .head_ferr(head_ferr),
    .head_brk(head_brk), .data_ready(data_ready), .overrun(overrun),
    .fifo_err(fifo_err), .trig_irq(trig_irq), .to_irq(to_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f,
                      input logic b, input bit accept);
    rx_valid = 1'b1; rx_byte = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    step();
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    if (accept) exp_q.push_back(b ? 8'h00 : d);
  endtask

  task automatic pop();
    host_rd = 1'b1;
    step();
    host_rd = 1'b0;
  endtask

  task automatic ctl(input logic [7:0] v);
    fcr_wr = 1'b1; fcr_data = v;
    step();
    fcr_wr = 1'b0;
    if (!v[0] || v[1]) exp_q.delete();
  endtask

  task automatic lsr();
    lsr_rd = 1'b1;
    step();
    lsr_rd = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1;
    step();
    char_tick = 1'b0;
  endtask

  // scoreboard monitor: compares the head byte during each read cycle
  always @(negedge clk) begin
    if (rst_n && host_rd && data_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected pop actual=0x%0h expected=none", head_data);
      end else begin
        chk("R2 head order", {24'h0, head_data}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00; rx_perr = 1'b0; rx_ferr = 1'b0;
    rx_brk = 1'b0; line_mark = 1'b0; start_seen = 1'b0; host_rd = 1'b0;
    lsr_rd = 1'b0; fcr_wr = 1'b0; fcr_data = 8'h00; char_tick = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 data_ready", data_ready, 0);
    chk("R1 trig_irq", trig_irq, 0);
    chk("R1 to_irq", to_irq, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 fifo_err", fifo_err, 0);

    // R11 one-character mode
    push(8'h11, 0, 0, 0, 1);
    chk("R11 data_ready", data_ready, 1);
    chk("R11 trig follows dr", trig_irq, 1);
    push(8'h22, 0, 0, 0, 0);
    chk("R11 second arrival overruns", overrun, 1);
    repeat (5) tick();
    chk("R11 no timeout", to_irq, 0);
    pop();
    chk("R11 empty after read", data_ready, 0);
    lsr();
    chk("R7 overrun cleared by lsr", overrun, 0);

    // R3 trigger levels
    ctl(8'h41);
    for (int i = 0; i < 3; i++) push(8'h30 + 8'(i), 0, 0, 0, 1);
    chk("R3 level4 below", trig_irq, 0);
    push(8'h33, 0, 0, 0, 1);
    chk("R3 level4 reached", trig_irq, 1);
    pop();
    chk("R3 level4 dropped", trig_irq, 0);
    repeat (3) pop();
    chk("R2 empty", data_ready, 0);

    ctl(8'hC1);
    for (int i = 0; i < 13; i++) push(8'h50 + 8'(i), 0, 0, 0, 1);
    chk("R3 level14 below", trig_irq, 0);
    push(8'h5D, 0, 0, 0, 1);
    chk("R3 level14 reached", trig_irq, 1);
    push(8'h5E, 0, 0, 0, 1);
    push(8'h5F, 0, 0, 0, 1);
    chk("R7 no overrun at full", overrun, 0);
    push(8'hEE, 0, 0, 0, 0);
    chk("R7 overrun when full", overrun, 1);
    repeat (3) pop();
    chk("R3 level14 dropped at 13", trig_irq, 0);
    repeat (13) pop();
    chk("R2 drained", data_ready, 0);
    lsr();

    // R6 disable flushes
    ctl(8'h81);
    for (int i = 0; i < 8; i++) push(8'h70 + 8'(i), 0, 0, 0, 1);
    chk("R3 level8 reached", trig_irq, 1);
    ctl(8'h40);
    chk("R6 disable empties", data_ready, 0);
    push(8'h91, 0, 0, 0, 1);
    push(8'h92, 0, 0, 0, 0);
    chk("R6 back to one slot", overrun, 1);
    pop();
    lsr();

    // R5 flush bit, self-clearing
    ctl(8'h81);
    for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i), 0, 0, 0, 1);
    ctl(8'h83);
    chk("R5 flush empties", data_ready, 0);
    push(8'hA5, 0, 0, 0, 1);
    ctl(8'h81);
    chk("R5 flush self-clears", data_ready, 1);
    pop();

    // R4 timeout
    ctl(8'h01);
    push(8'hB1, 0, 0, 0, 1);
    repeat (3) tick();
    chk("R4 three ticks", to_irq, 0);
    tick();
    chk("R4 four ticks", to_irq, 1);
    push(8'hB2, 0, 0, 0, 1);
    chk("R4 arrival restarts", to_irq, 0);
    repeat (4) tick();
    chk("R4 fires again", to_irq, 1);
    pop();
    chk("R4 read clears", to_irq, 0);
    chk("R4 still data", data_ready, 1);
    repeat (3) tick();
    chk("R4 read restarted count", to_irq, 0);
    pop();
    repeat (5) tick();
    chk("R4 no timeout when empty", to_irq, 0);

    // R8 / R9 error flags
    push(8'h33, 0, 0, 0, 1);
    push(8'h44, 1, 0, 0, 1);
    push(8'h55, 0, 1, 0, 1);
    chk("R9 error stored", fifo_err, 1);
    chk("R8 clean head", head_perr, 0);
    pop();
    chk("R8 parity at head", head_perr, 1);
    lsr();
    chk("R9 stays while stored", fifo_err, 1);
    pop();
    chk("R8 framing at head", head_ferr, 1);
    chk("R8 parity gone", head_perr, 0);
    pop();
    chk("R9 latched after pop", fifo_err, 1);
    lsr();
    chk("R9 cleared by lsr", fifo_err, 0);

    // R10 break handling
    push(8'hAA, 0, 0, 1, 1);
    chk("R10 break byte zero", head_data, 8'h00);
    chk("R10 break flag", head_brk, 1);
    push(8'h66, 0, 0, 0, 0);
    pop();
    chk("R10 load blocked", data_ready, 0);
    start_seen = 1'b1; step(); start_seen = 1'b0;
    push(8'h67, 0, 0, 0, 0);
    chk("R10 start without mark ignored", data_ready, 0);
    line_mark = 1'b1; step(); line_mark = 1'b0;
    start_seen = 1'b1; step(); start_seen = 1'b0;
    push(8'h77, 0, 0, 0, 1);
    chk("R10 reopened", data_ready, 1);
    pop();
    lsr();

    chk("R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule